// File: doc/BRIEF.md
# Protection FET Request Arbiter

This block produces the on/off drive requests for a battery pack's charge FET and discharge FET. It combines two sources of control. The first is the autonomous response to protection faults: each fault line is steered by two mask vectors to the charge FET, to the discharge FET, to both or to neither. The second is a set of host override commands that can force either FET on or off. The autonomous path is active only while an enable bit is set. That bit has a reset value chosen by parameter, and a single-cycle strobe inverts it.

Host force commands are captured on a write strobe and held until the next write or until reset. Two permission inputs can separately block the force-off direction and the force-on direction. A blocked command is never stored, and while a permission is withdrawn any force already held in that direction has no effect. When the autonomous path is off and no force is active, faults are only reported and both requests stay on. The gate drivers, precharge PWM and bus decoding sit outside the block.

Top module: `fet_guard_arbiter`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, both FET requests are 0. The autonomous enable starts at the parameter AUTO_EN_RESET, which is 1 by default.
- R2: A one-cycle pulse on autoToggle inverts the autonomous enable. The change shows in the FET requests two clock edges after the pulse is sampled.
- R3: With the autonomous path on and no host force active, fault bit i drives chgFetOn low when chgMask[i] is 1, and drives dsgFetOn low when dsgMask[i] is 1. A fault bit whose mask bits are both 0 affects neither FET.
- R4: With the autonomous path off and no host force active, both requests are 1 whatever the fault vector holds.
- R5: In the force vectors, bit 0 is the charge FET and bit 1 is the discharge FET. A permitted force-on drives that FET's request to 1 even when a mapped fault is active.
- R6: A permitted force-off drives that FET's request to 0 under all conditions. It wins over a force-on for the same FET.
- R7: Force commands are loaded only when hostWr is 1, and both vectors are replaced at once. Changing the force inputs without a write has no effect on the requests.
- R8: While allowForceOff is 0, written force-off bits are stored as 0, and any force-off already held has no effect on the requests.
- R9: While allowForceOn is 0, written force-on bits are stored as 0, and any force-on already held has no effect on the requests.
- R10: A change on the fault vector or the masks reaches the requests one clock edge after it is sampled. A host write takes two clock edges to reach the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultVec | input | NUM_FAULTS | Active protection faults, one bit per protection |
| chgMask | input | NUM_FAULTS | Bit i set: fault i turns off the charge FET |
| dsgMask | input | NUM_FAULTS | Bit i set: fault i turns off the discharge FET |
| autoToggle | input | 1 | Single-cycle strobe that inverts the autonomous enable |
| hostWr | input | 1 | Loads the host force vectors |
| hostForceOn | input | 2 | Force-on request; bit 0 is charge, bit 1 is discharge |
| hostForceOff | input | 2 | Force-off request; bit 0 is charge, bit 1 is discharge |
| allowForceOn | input | 1 | Permits host force-on |
| allowForceOff | input | 1 | Permits host force-off |
| chgFetOn | output | 1 | Charge FET enable request |
| dsgFetOn | output | 1 | Discharge FET enable request |

## Verification
The fault routing is tried with three kinds of fault: one mapped only to the charge FET, one mapped only to the discharge FET, and one mapped to both. It is also tried with an unmapped fault, which shows whether the two masks are kept apart and whether an unmapped fault is correctly left alone. Host forces are applied with a fault present and with no fault, and with both directions set at once. This separates the override from the autonomous result and confirms that force-off wins. Each permission input is withdrawn both before a write and while a force is already held, which covers the storage path and the use path separately. A behavioural model compares both requests on every clock, so that the one-edge and two-edge latencies are also checked.

// File: rtl/fet_arb_pkg.sv
package fet_arb_pkg;
  localparam int NUM_FETS = 2;
  localparam int FET_CHG  = 0;
  localparam int FET_DSG  = 1;

  // Strobes and levels passed from the control module to the datapath.
  // Force bits are already qualified by their permission inputs.
  typedef struct packed {
    logic                autoEn;
    logic [NUM_FETS-1:0] forceOn;
    logic [NUM_FETS-1:0] forceOff;
  } fetCtl_t;
endpackage

// File: rtl/fet_arb_ctrl.sv
module fet_arb_ctrl
  import fet_arb_pkg::*;
#(
  parameter bit AUTO_EN_RESET = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                autoToggle,
  input  logic                hostWr,
  input  logic [NUM_FETS-1:0] hostForceOn,
  input  logic [NUM_FETS-1:0] hostForceOff,
  input  logic                allowForceOn,
  input  logic                allowForceOff,
  output fetCtl_t             ctl
);
  logic                autoEnQ;
  logic [NUM_FETS-1:0] onHeldQ;
  logic [NUM_FETS-1:0] offHeldQ;

  // Autonomous enable: loads its reset value, then flips on each strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           autoEnQ <= AUTO_EN_RESET;
    else if (autoToggle) autoEnQ <= ~autoEnQ;
  end

  // Host force vectors: a write replaces both, and blocked directions store 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onHeldQ  <= '0;
      offHeldQ <= '0;
    end else if (hostWr) begin
      onHeldQ  <= allowForceOn  ? hostForceOn  : '0;
      offHeldQ <= allowForceOff ? hostForceOff : '0;
    end
  end

  always_comb begin
    ctl.autoEn   = autoEnQ;
    ctl.forceOn  = onHeldQ  & {NUM_FETS{allowForceOn}};
    ctl.forceOff = offHeldQ & {NUM_FETS{allowForceOff}};
  end

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    autoToggle |=> (ctl.autoEn != $past(ctl.autoEn))); // R2
  AST_NO_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !autoToggle |=> $stable(ctl.autoEn)); // R2
  AST_OFF_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !allowForceOff) |=> (offHeldQ == '0)); // R8
  AST_ON_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !allowForceOn) |=> (onHeldQ == '0)); // R9
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !hostWr |=> ($stable(onHeldQ) && $stable(offHeldQ))); // R7
endmodule

// File: rtl/fet_arb_datapath.sv
module fet_arb_datapath
  import fet_arb_pkg::*;
#(
  parameter int NUM_FAULTS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fetCtl_t               ctl,
  input  logic [NUM_FAULTS-1:0] faultVec,
  input  logic [NUM_FAULTS-1:0] chgMask,
  input  logic [NUM_FAULTS-1:0] dsgMask,
  output logic [NUM_FETS-1:0]   fetReq
);
  logic [NUM_FAULTS-1:0] laneMask [NUM_FETS];
  logic [NUM_FETS-1:0]   laneHit;
  logic [NUM_FETS-1:0]   laneNext;

  assign laneMask[FET_CHG] = chgMask;
  assign laneMask[FET_DSG] = dsgMask;

  for (genvar f = 0; f < NUM_FETS; f++) begin : gLane
    assign laneHit[f] = |(faultVec & laneMask[f]);

    // Priority: forced off, forced on, autonomous shutoff, default on.
    always_comb begin
      if (ctl.forceOff[f])                 laneNext[f] = 1'b0;
      else if (ctl.forceOn[f])             laneNext[f] = 1'b1;
      else if (ctl.autoEn && laneHit[f])   laneNext[f] = 1'b0;
      else                                 laneNext[f] = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) fetReq[f] <= 1'b0;
      else       fetReq[f] <= laneNext[f];
    end

    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rstN)
      ctl.forceOff[f] |=> !fetReq[f]); // R6
    AST_ON_OVERRIDES: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.forceOn[f] && !ctl.forceOff[f]) |=> fetReq[f]); // R5
    AST_AUTO_SHUTS: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.autoEn && (|(faultVec & laneMask[f])) && !ctl.forceOn[f] && !ctl.forceOff[f])
        |=> !fetReq[f]); // R3
    AST_PASSIVE_ON: assert property (@(posedge clk) disable iff (!rstN)
      (!ctl.autoEn && !ctl.forceOff[f]) |=> fetReq[f]); // R4
  end
endmodule

// File: rtl/fet_guard_arbiter.sv
module fet_guard_arbiter
  import fet_arb_pkg::*;
#(
  parameter int NUM_FAULTS    = 16,
  parameter bit AUTO_EN_RESET = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_FAULTS-1:0] faultVec,
  input  logic [NUM_FAULTS-1:0] chgMask,
  input  logic [NUM_FAULTS-1:0] dsgMask,
  input  logic                  autoToggle,
  input  logic                  hostWr,
  input  logic [1:0]            hostForceOn,
  input  logic [1:0]            hostForceOff,
  input  logic                  allowForceOn,
  input  logic                  allowForceOff,
  output logic                  chgFetOn,
  output logic                  dsgFetOn
);
  fetCtl_t             ctlBus;
  logic [NUM_FETS-1:0] fetReq;

  fet_arb_ctrl #(.AUTO_EN_RESET(AUTO_EN_RESET)) uCtrl (
    .clk(clk), .rstN(rstN), .autoToggle(autoToggle), .hostWr(hostWr),
    .hostForceOn(hostForceOn), .hostForceOff(hostForceOff),
    .allowForceOn(allowForceOn), .allowForceOff(allowForceOff), .ctl(ctlBus)
  );

  fet_arb_datapath #(.NUM_FAULTS(NUM_FAULTS)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .faultVec(faultVec),
    .chgMask(chgMask), .dsgMask(dsgMask), .fetReq(fetReq)
  );

  assign chgFetOn = fetReq[FET_CHG];
  assign dsgFetOn = fetReq[FET_DSG];

  AST_RESET_OFF: assert property (@(posedge clk)
    !rstN |=> (!chgFetOn && !dsgFetOn)); // R1
endmodule

// File: tb/fet_guard_arbiter_test.sv
module fet_guard_arbiter_test;
  localparam int NF = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NF-1:0] faultVec = '0, chgMask = '0, dsgMask = '0;
  logic autoToggle = 1'b0, hostWr = 1'b0;
  logic [1:0] hostForceOn = '0, hostForceOff = '0;
  logic allowForceOn = 1'b1, allowForceOff = 1'b1;
  logic chgFetOn, dsgFetOn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fet_guard_arbiter #(.NUM_FAULTS(NF), .AUTO_EN_RESET(1'b1)) uut (
    .clk(clk), .rstN(rstN), .faultVec(faultVec), .chgMask(chgMask), .dsgMask(dsgMask),
    .autoToggle(autoToggle), .hostWr(hostWr), .hostForceOn(hostForceOn),
    .hostForceOff(hostForceOff), .allowForceOn(allowForceOn),
    .allowForceOff(allowForceOff), .chgFetOn(chgFetOn), .dsgFetOn(dsgFetOn)
  );

  // Behavioural reference model built from the requirements.
  bit mAuto;
  bit [1:0] mOn, mOff, mReq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAuto = 1'b1; mOn = '0; mOff = '0; mReq = '0;
    end else begin
      bit [1:0] nxt;
      for (int f = 0; f < 2; f++) begin
        bit hit;
        hit = (f == 0) ? ((faultVec & chgMask) != 0) : ((faultVec & dsgMask) != 0);
        if (mOff[f] && allowForceOff)  nxt[f] = 1'b0;
        else if (mOn[f] && allowForceOn) nxt[f] = 1'b1;
        else if (mAuto && hit)         nxt[f] = 1'b0;
        else                           nxt[f] = 1'b1;
      end
      mReq = nxt;
      if (autoToggle) mAuto = !mAuto;
      if (hostWr) begin
        mOn  = allowForceOn  ? hostForceOn  : 2'b00;
        mOff = allowForceOff ? hostForceOff : 2'b00;
      end
    end
  end

  // Model comparison on every clock (R10 timing).
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if ({dsgFetOn, chgFetOn} !== mReq) begin
        failures++;
        $display("FAIL R10 model compare: actual=%b expected=%b at %0t",
                 {dsgFetOn, chgFetOn}, mReq, $time);
      end
    end
  end

  task automatic expect2(input bit eChg, input bit eDsg, input string req);
    checks++;
    if (chgFetOn !== eChg || dsgFetOn !== eDsg) begin
      failures++;
      $display("FAIL %s: actual chg=%b dsg=%b expected chg=%b dsg=%b",
               req, chgFetOn, dsgFetOn, eChg, eDsg);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseToggle();
    autoToggle = 1'b1;
    @(negedge clk);
    autoToggle = 1'b0;
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] on, input logic [1:0] off);
    hostForceOn = on; hostForceOff = off; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect2(1'b0, 1'b0, "R1 during reset");
    chgMask = 16'h010F; dsgMask = 16'h01F0;
    rstN = 1'b1;
    expect2(1'b0, 1'b0, "R1 first sample after reset");
    settle();
    expect2(1'b1, 1'b1, "R3 no fault");

    // R10: fault appears one edge later
    faultVec = 16'h0001;
    @(negedge clk);
    expect2(1'b0, 1'b1, "R10 fault one-edge latency");
    expect2(1'b0, 1'b1, "R1 auto default on / R3 charge-only fault");
    faultVec = 16'h0020; settle();
    expect2(1'b1, 1'b0, "R3 discharge-only fault");
    faultVec = 16'h0100; settle();
    expect2(1'b0, 1'b0, "R3 fault mapped to both");
    faultVec = 16'h1000; settle();
    expect2(1'b1, 1'b1, "R3 unmapped fault");

    // R2 / R4: autonomous off, faults have no effect
    faultVec = 16'h0100;
    settle();
    pulseToggle();
    expect2(1'b1, 1'b1, "R2 toggle off after two edges");
    expect2(1'b1, 1'b1, "R4 passive with fault");
    pulseToggle();
    expect2(1'b0, 1'b0, "R2 toggle back on");

    // R5: force-on charge with fault active
    hostWrite(2'b01, 2'b00);
    expect2(1'b1, 1'b0, "R5 force-on charge over fault");
    expect2(1'b1, 1'b0, "R10 host write two-edge latency");

    // R7: inputs change without a write
    hostForceOn = 2'b11; hostForceOff = 2'b11; settle();
    expect2(1'b1, 1'b0, "R7 no write no change");

    // R6: force-off wins over force-on
    hostWrite(2'b11, 2'b01);
    expect2(1'b0, 1'b1, "R6 off beats on");
    faultVec = '0; pulseToggle(); settle();
    expect2(1'b0, 1'b1, "R6 off with auto off and no fault");

    // R8: blocked force-off
    allowForceOff = 1'b0; settle();
    expect2(1'b1, 1'b1, "R8 held force-off masked");
    hostWrite(2'b00, 2'b11);
    expect2(1'b1, 1'b1, "R8 blocked write ignored");
    allowForceOff = 1'b1; settle();
    expect2(1'b1, 1'b1, "R8 blocked bits never stored");

    // R9: blocked force-on, autonomous on with fault
    pulseToggle();
    faultVec = 16'h0100;
    hostWrite(2'b11, 2'b00);
    expect2(1'b1, 1'b1, "R9 permitted force-on baseline");
    allowForceOn = 1'b0; settle();
    expect2(1'b0, 1'b0, "R9 held force-on masked");
    hostWrite(2'b11, 2'b00);
    allowForceOn = 1'b1; settle();
    expect2(1'b0, 1'b0, "R9 blocked write never stored");

    // R7: host clears forces
    hostWrite(2'b00, 2'b00); faultVec = '0; settle();
    expect2(1'b1, 1'b1, "R7 cleared by write");

    // R1: reset mid-run
    rstN = 1'b0; @(negedge clk);
    expect2(1'b0, 1'b0, "R1 reset asserted mid-run");
    rstN = 1'b1; faultVec = 16'h0001; settle();
    expect2(1'b0, 1'b1, "R1 auto re-enabled after reset");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule